// File: doc/BRIEF.md
# Byte Serial Peripheral Controller with Register Access

This block is a full-duplex, byte-wide SPI controller that is reached through a small 8-bit register bus of the kind found inside a microcontroller. Software sets it up through a control register. Through that register it switches the controller on, picks master or slave operation, chooses the clock idle level and the clock phase, and selects one of four master clock rates. A data register starts or preloads a transfer and returns the byte received last. A status register holds a completion flag and a collision flag. Software must clear both flags itself.

As master, a write to the data register while the controller is idle starts a transfer. The controller then lowers its select output for one byte and produces eight clock periods derived from the system clock. It shifts the byte out MSB first and shifts in the serial input at the same time. As slave, it loads the byte to send ahead of time and follows an external clock and select, paying no attention to the rate setting. An interrupt request is raised while the completion flag is set, but only when both the local interrupt enable and an external serial-port enable are high.

Top module: `spi_sfr_ctrl`

## Requirements
- R1: In master mode the SCK period equals 4, 16, 64 or 128 system clocks for rate codes 0, 1, 2 and 3 in control bits [1:0]. Every SCK edge follows the one before it by half that period.
- R2: A transfer moves eight bits MSB first over 16 SCK edges. The byte written to the data register (address 2) appears on `sdo`. The byte shifted in on `sdi` can be read from the data register once the transfer completes.
- R3: The clock phase is set by control bit 2. At 0, `sdo` is valid before the first edge, bits are sampled on odd (leading) edges and shifted on even edges. At 1, bits are sampled on even (trailing) edges and move on odd edges.
- R4: The controller is in master mode when control bit 6 (enable) and control bit 4 (master) are both set. In master mode, a data write while idle starts a transfer. `ss_n_o` is low from the start through the 16th edge and is high again afterwards.
- R5: SCK idles at the level of control bit 3: low for 0, high for 1.
- R6: Status bit 7 (completion) goes to 1 when a byte finishes and stays set. A status write with bit 7 at 0 clears it. A write with bit 7 at 1 leaves it unchanged.
- R7: A data write during an active transfer sets status bit 6 (collision). The write is ignored, so the byte in flight is sent unchanged. The collision bit clears only through a status write with bit 6 at 0.
- R8: `irq_o` is high exactly when status bit 7, control bit 7 (interrupt enable) and `sys_irq_en` are all 1.
- R9: After reset every register reads 0. Status bits [5:0] and control bit 5 always read 0.
- R10: The controller is in slave mode when control bit 6 is set and control bit 4 is clear. In slave mode a data write while idle preloads the byte to send. The transfer follows `sck_i` while `ss_n_i` is low, and it gives the same result whatever the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sfr_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| sfr_wr | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for the selected register |
| sys_irq_en | input | 1 | External serial-port interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock |
| sck_i | input | 1 | Slave serial clock, synchronous to clk |
| ss_n_o | output | 1 | Master select output, active low |
| ss_n_i | input | 1 | Slave select input, active low |
| sdo | output | 1 | Serial data out (MOSI as master, MISO as slave) |
| sdi | input | 1 | Serial data in (MISO as master, MOSI as slave) |

## Verification
The assertions assume that the rate and mode bits stay fixed while a transfer is in flight. They also assume that `sck_i` and `ss_n_i` change in step with the system clock, so that one level change on `sck_i` counts as exactly one edge. The stimulus changes the control register only between transfers and drives the slave clock and select on falling system-clock edges. Each slave clock level is held for six system clocks. It starts a collision write only at the slowest rate, so the write and the status read back both fit inside one SCK half period.

// File: rtl/spi_sfr_pkg.sv
package spi_sfr_pkg;
    localparam int DATA_W  = 8;
    localparam int EDGES   = 2 * DATA_W;
    localparam int EDGE_W  = $clog2(EDGES + 1);
    localparam int RATE_W  = 2;
    localparam int DIV_W   = 7;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int B_IRQEN  = 7;
    localparam int B_EN     = 6;
    localparam int B_MASTER = 4;
    localparam int B_CPOL   = 3;
    localparam int B_CPHA   = 2;
    localparam int B_DONE   = 7;
    localparam int B_WCOL   = 6;

    typedef struct packed {
        logic              busy;
        logic              sck;
        logic              ss_n;
        logic [DATA_W-1:0] shreg;
        logic              rx_bit;
        logic [EDGE_W-1:0] cnt;
        logic              sck_prev;
    } eng_t;

    typedef struct packed {
        logic              irq_en;
        logic              en;
        logic              master;
        logic              cpol;
        logic              cpha;
        logic [RATE_W-1:0] rate;
        logic              done;
        logic              wcol;
        logic [DATA_W-1:0] rxd;
    } regs_t;

    function automatic int half_len(input logic [RATE_W-1:0] code);
        case (code)
            2'd0:    return 2;
            2'd1:    return 8;
            2'd2:    return 32;
            default: return 64;
        endcase
    endfunction
endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div
    import spi_sfr_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q, half;

    always_comb begin
        half  = CNT_W'(half_len(rate));
        tick  = run && (cnt_q == half - 1'b1);
        cnt_d = cnt_q + 1'b1;
        if (!run || tick) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: the count advances by one each cycle between ticks
    a_r1_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && !$past(tick) |-> cnt_q == $past(cnt_q) + 1'b1);

    // R1: the count never passes the selected half period
    a_r1_below_half: assert property (@(posedge clk) disable iff (!rst_n)
        run && $stable(rate) |-> cnt_q < half);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              master,
    input  logic              cpol,
    input  logic              cpha,
    input  logic [RATE_W-1:0] rate,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sck_i,
    input  logic              ss_n_i,
    input  logic              sdi,
    output logic              sck_o,
    output logic              ss_n_o,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    eng_t              q, d;
    logic              tick, ev, lead, sample;
    logic [EDGE_W-1:0] n;

    spi_rate_div u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (en && master && q.busy),
        .rate (rate),
        .tick (tick)
    );

    always_comb begin
        d          = q;
        d.sck_prev = sck_i;
        done       = 1'b0;
        ev         = 1'b0;
        rx_byte    = {q.shreg[DATA_W-2:0], cpha ? sdi : q.rx_bit};
        if (!en) begin
            d.busy = 1'b0;
            d.cnt  = '0;
            d.ss_n = 1'b1;
            d.sck  = cpol;
        end else if (master) begin
            if (!q.busy) begin
                d.sck  = cpol;
                d.ss_n = 1'b1;
                if (load) begin
                    d.shreg = wdata;
                    d.busy  = 1'b1;
                    d.ss_n  = 1'b0;
                    d.cnt   = '0;
                end
            end else if (tick) begin
                d.sck = ~q.sck;
                ev    = 1'b1;
            end
        end else begin
            d.sck  = cpol;
            d.ss_n = 1'b1;
            if (load && !q.busy) d.shreg = wdata;
            if (ss_n_i) begin
                d.busy = 1'b0;
                d.cnt  = '0;
            end else if (sck_i != q.sck_prev) begin
                ev     = 1'b1;
                d.busy = 1'b1;
            end
        end

        n      = q.cnt + 1'b1;
        lead   = n[0];
        sample = lead ^ cpha;
        if (ev) begin
            d.cnt = n;
            if (sample) d.rx_bit = sdi;
            if (n == EDGE_W'(EDGES)) begin
                d.shreg = rx_byte;
                done    = 1'b1;
                d.busy  = 1'b0;
                d.cnt   = '0;
                d.ss_n  = 1'b1;
            end else if (!sample && n != 1) begin
                d.shreg = {q.shreg[DATA_W-2:0], q.rx_bit};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.ss_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_o  = q.sck;
    assign ss_n_o = q.ss_n;
    assign sdo    = q.shreg[DATA_W-1];
    assign busy   = q.busy;

    // R4: select stays low for the whole master byte
    a_r4_ss_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        en && master && q.busy |-> !ss_n_o);

    // R5: idle master clock sits at the polarity level
    a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
        en && master && !q.busy && $past(en && master && !q.busy) && $stable(cpol)
        |-> sck_o == cpol);

    // R7: between clock edges the byte in flight is untouched, writes included
    a_r7_shreg_held: assert property (@(posedge clk) disable iff (!rst_n)
        en && master && q.busy && !tick |=> $stable(q.shreg));

    // R2: never more than 16 edges in a byte
    a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt < EDGE_W'(EDGES));
endmodule

// File: rtl/spi_sfr_ctrl.sv
module spi_sfr_ctrl
    import spi_sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic              sys_irq_en,
    output logic              irq_o,
    output logic              sck_o,
    input  logic              sck_i,
    output logic              ss_n_o,
    input  logic              ss_n_i,
    output logic              sdo,
    input  logic              sdi
);
    regs_t             q, d;
    logic              eng_busy, eng_done, wr_data, collide, load;
    logic [DATA_W-1:0] rx_byte;

    assign wr_data = sfr_wr && (sfr_addr == A_DATA);
    assign collide = wr_data && eng_busy;
    assign load    = wr_data && !eng_busy;

    spi_shift_engine u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (q.en),
        .master (q.master),
        .cpol   (q.cpol),
        .cpha   (q.cpha),
        .rate   (q.rate),
        .load   (load),
        .wdata  (sfr_wdata),
        .sck_i  (sck_i),
        .ss_n_i (ss_n_i),
        .sdi    (sdi),
        .sck_o  (sck_o),
        .ss_n_o (ss_n_o),
        .sdo    (sdo),
        .busy   (eng_busy),
        .done   (eng_done),
        .rx_byte(rx_byte)
    );

    always_comb begin
        d = q;
        if (sfr_wr && sfr_addr == A_CTRL) begin
            d.irq_en = sfr_wdata[B_IRQEN];
            d.en     = sfr_wdata[B_EN];
            d.master = sfr_wdata[B_MASTER];
            d.cpol   = sfr_wdata[B_CPOL];
            d.cpha   = sfr_wdata[B_CPHA];
            d.rate   = sfr_wdata[RATE_W-1:0];
        end
        if (sfr_wr && sfr_addr == A_STAT) begin
            d.done = q.done & sfr_wdata[B_DONE];
            d.wcol = q.wcol & sfr_wdata[B_WCOL];
        end
        if (collide) d.wcol = 1'b1;
        if (eng_done) begin
            d.done = 1'b1;
            d.rxd  = rx_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (sfr_addr)
            A_CTRL:  sfr_rdata = {q.irq_en, q.en, 1'b0, q.master, q.cpol, q.cpha, q.rate};
            A_STAT:  sfr_rdata = {q.done, q.wcol, 6'b0};
            A_DATA:  sfr_rdata = q.rxd;
            default: sfr_rdata = '0;
        endcase
    end

    assign irq_o = q.done && q.irq_en && sys_irq_en;

    // R7: a data write during a transfer raises the collision flag
    a_r7_wcol_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && eng_busy |=> sfr_rdata[B_WCOL] || sfr_addr != A_STAT);

    // R6: completion flag survives anything but a clearing status write
    a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.done && !(sfr_wr && sfr_addr == A_STAT && !sfr_wdata[B_DONE]) |=> q.done);

    // R7: collision flag survives anything but a clearing status write
    a_r7_wcol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.wcol && !(sfr_wr && sfr_addr == A_STAT && !sfr_wdata[B_WCOL]) |=> q.wcol);

    // R8: a request never appears without the external enable
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> sys_irq_en && q.irq_en);

    // R9: reserved status bits read zero
    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_addr == A_STAT |-> sfr_rdata[5:0] == 6'b0);
endmodule

// File: tb/spi_sfr_ctrl_bench.sv
module spi_sfr_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] sfr_addr = 2'd0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'd0;
    logic [7:0] sfr_rdata;
    logic       sys_irq_en = 1'b1;
    logic       irq_o, sck_o, ss_n_o, sdo;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, sdi = 1'b0;
    logic       last_sdo = 1'b0;
    int         cyc = 0;
    int         n_run = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        cyc      = cyc + 1;
        last_sdo = sdo;
    end

    spi_sfr_ctrl u_spi_sfr_ctrl (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sys_irq_en(sys_irq_en),
        .irq_o(irq_o), .sck_o(sck_o), .sck_i(sck_i), .ss_n_o(ss_n_o),
        .ss_n_i(ss_n_i), .sdo(sdo), .sdi(sdi)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = v; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        sfr_addr = a;
        #1 v = sfr_rdata;
    endtask

    task automatic master_xfer(input int rate, input bit cpol, input bit cpha,
                               input logic [7:0] tx, input logic [7:0] rx,
                               input bit collide);
        logic [7:0] got, v;
        int half, t_prev, bad_gap;
        bit ss_bad;
        half = (rate == 0) ? 2 : (rate == 1) ? 8 : (rate == 2) ? 32 : 64;
        got = 8'd0; bad_gap = 0; ss_bad = 1'b0; t_prev = 0;
        wr(2'd0, {1'b1, 1'b1, 1'b0, 1'b1, cpol, cpha, 2'(rate)});
        wr(2'd1, 8'h00);
        repeat (2) @(negedge clk);
        chk(sck_o == cpol, "R5 idle level", sck_o, cpol);
        sdi = cpha ? 1'b0 : rx[7];
        wr(2'd2, tx);
        for (int n = 1; n <= 16; n++) begin
            @(sck_o);
            if (n > 1 && (cyc - t_prev) != half) bad_gap++;
            t_prev = cyc;
            if (ss_n_o !== 1'b0 && n < 16) ss_bad = 1'b1;
            if (((n % 2) == 1) ^ cpha) got = {got[6:0], last_sdo};
            else if (cpha == 1'b0 && n < 16) sdi = rx[7 - n / 2];
            else if (cpha == 1'b1) sdi = rx[7 - (n - 1) / 2];
            if (collide && n == 5) begin
                wr(2'd2, 8'hC3);
                rd(2'd1, v);
                chk(v == 8'h40, "R7 collision flag mid-byte", v, 8'h40);
            end
        end
        chk(bad_gap == 0, "R1 edge spacing", bad_gap, 0);
        chk(!ss_bad, "R4 select low during byte", ss_bad, 0);
        chk(got == tx, collide ? "R7 byte unchanged after collision" : "R2 R3 sdo byte", got, tx);
        repeat (2) @(negedge clk);
        chk(ss_n_o == 1'b1, "R4 select released", ss_n_o, 1);
        chk(sck_o == cpol, "R5 idle after byte", sck_o, cpol);
        rd(2'd1, v);
        chk(v == (collide ? 8'hC0 : 8'h80), "R6 completion status", v, collide ? 8'hC0 : 8'h80);
        rd(2'd2, v);
        chk(v == rx, "R2 R3 received byte", v, rx);
        chk(irq_o == 1'b1, "R8 irq with both enables", irq_o, 1);
    endtask

    task automatic slave_xfer(input int rate, input bit cpol, input bit cpha,
                              input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] got, v;
        got = 8'd0;
        wr(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, cpol, cpha, 2'(rate)});
        wr(2'd1, 8'h00);
        @(negedge clk);
        sck_i = cpol; ss_n_i = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd2, tx);
        sdi = cpha ? 1'b0 : rx[7];
        ss_n_i = 1'b0;
        repeat (3) @(negedge clk);
        for (int n = 1; n <= 16; n++) begin
            if (((n % 2) == 1) ^ cpha) got = {got[6:0], sdo};
            sck_i = ~sck_i;
            if (!(((n % 2) == 1) ^ cpha)) begin
                if (cpha == 1'b0 && n < 16) sdi = rx[7 - n / 2];
                else if (cpha == 1'b1) sdi = rx[7 - (n - 1) / 2];
            end
            repeat (6) @(negedge clk);
        end
        ss_n_i = 1'b1;
        chk(got == tx, "R10 slave sdo byte", got, tx);
        rd(2'd1, v);
        chk(v == 8'h80, "R10 slave completion", v, 8'h80);
        rd(2'd2, v);
        chk(v == rx, "R10 slave received byte", v, rx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        rd(2'd0, v); chk(v == 8'h00, "R9 control after reset", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R9 status after reset", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R9 data after reset", v, 0);
        chk(irq_o == 1'b0, "R9 irq after reset", irq_o, 0);
        chk(ss_n_o == 1'b1 && sck_o == 1'b0, "R9 pins after reset", {ss_n_o, sck_o}, 2);
        wr(2'd0, 8'hFF);
        rd(2'd0, v); chk(v == 8'hDF, "R9 control bit5 reads zero", v, 8'hDF);

        // R1 R2 R3 R5: sweep of rates and clock modes
        for (int r = 0; r < 4; r++)
            for (int m = 0; m < 4; m++)
                master_xfer(r, m[1], m[0], 8'(8'hA5 ^ (r * 37 + m * 11)),
                            8'(8'h5A ^ (r * 19 + m * 53)), 1'b0);
        // R2 boundary patterns at the fastest rate
        for (int m = 0; m < 4; m++) begin
            master_xfer(0, m[1], m[0], 8'h00, 8'hFF, 1'b0);
            master_xfer(0, m[1], m[0], 8'h80, 8'h01, 1'b0);
        end
        // R7 collision at the slowest rate
        master_xfer(3, 1'b0, 1'b0, 8'h3C, 8'h96, 1'b1);
        master_xfer(3, 1'b1, 1'b1, 8'h69, 8'h0F, 1'b1);

        // R6 R7 R8 flag clearing and interrupt gating
        sys_irq_en = 1'b0; @(negedge clk);
        chk(irq_o == 1'b0, "R8 irq masked by external enable", irq_o, 0);
        sys_irq_en = 1'b1;
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk(v == 8'hC0, "R6 writing ones has no effect", v, 8'hC0);
        wr(2'd1, 8'h7F);
        rd(2'd1, v); chk(v == 8'h40, "R6 completion cleared alone", v, 8'h40);
        chk(irq_o == 1'b0, "R8 irq drops with completion", irq_o, 0);
        wr(2'd1, 8'h80);
        rd(2'd1, v); chk(v == 8'h00, "R7 collision cleared", v, 0);
        master_xfer(1, 1'b0, 1'b1, 8'hC6, 8'h39, 1'b0);
        wr(2'd0, 8'h51);
        @(negedge clk);
        chk(irq_o == 1'b0, "R8 irq masked by local enable", irq_o, 0);

        // R10 slave mode, two rates give the same result
        for (int r = 0; r < 4; r += 3)
            for (int m = 0; m < 4; m++)
                slave_xfer(r, m[1], m[0], 8'(8'hE1 ^ (m * 29)), 8'(8'h1E ^ (m * 71)));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule